// File: doc/BRIEF.md
# Group-Column Event Selection Matrix

This block steers raw hardware events to a bank of event counters. Raw events are organised as a matrix of groups (columns) by codes (rows). A 64-bit residency register holds one selected code per group. Each group therefore yields a single selected event line, which is registered once. The top bit of the residency register gates every group line at once. Each counter has a type register that chooses which group's line it follows, and a filter register that decides, from the originator of the event, whether the event may pass. The outputs are one increment pulse per counter. The counters themselves live elsewhere.

Software changes one group's code by presenting a 12-bit identifier. Bits 11:4 are the code and bits 3:0 are the group. A small update sequencer performs a read-modify-write of the residency register. It replaces only the addressed group's 8-bit field and sets the global enable bit. The sequencer has three states:
- `UPD_IDLE` waits for an identifier. A valid identifier moves it to `UPD_FETCH`; an invalid one keeps it in `UPD_IDLE`.
- `UPD_FETCH` takes a snapshot of the register. It moves to `UPD_COMMIT`, or aborts back to `UPD_IDLE` on a direct register write.
- `UPD_COMMIT` writes the merged value and always returns to `UPD_IDLE`.

The whole residency register can also be written directly through the configuration port. Because a counter selects a group and not a code, two counters can never observe two different codes of the same group.

Top module: `evsel_matrix`

## Requirements
- R1: For each group g, the selected line is the event input bit at index g*256 + code, where code is the 8-bit field at residency bits 8g+7..8g. A counter whose type register holds g pulses `inc_o` in the cycle after that input bit is high, and does not pulse for any other code of that group.
- R2: While residency bit 63 is clear, no counter pulses, whatever the event inputs.
- R3: An identifier write with group field 0..7 finishes in the third clock edge after it is accepted. It replaces only that group's 8-bit code field, leaves the other groups' codes unchanged, and sets bit 63.
- R4: An identifier whose group field (bits 3:0) is 8 or above is ignored. This includes 0x0FE, the value reserved for the cycle counter.
- R5: An identifier presented while an update is still in progress (state not `UPD_IDLE`) is dropped.
- R6: A configuration write to address 0x410 loads all 64 residency bits. It marks every group as programmed and cancels any update in progress.
- R7: The type register of counter i is at address 0x424 + 0x10*i and keeps data bits 3:0. A value of 8 or more selects no group, so the counter gets no increments.
- R8: A group that has not been programmed since reset never drives an increment. A group becomes programmed through an identifier write or a direct write.
- R9: The filter register of counter i is at address 0x423 + 0x10*i and keeps data bits 31:0. The value 0x000E0007 passes every event; this is also the reset value.
- R10: Any other filter value passes an event only when the filter bit whose index equals `orig_i` (bits 1:0) is set. `orig_i` is sampled together with the events.
- R11: After reset the residency register is zero with the enable clear, no group is programmed, every type register is 0, and every filter is all-sources. No counter pulses.
- R12: Several counters typed to the same group pulse together. Counters typed to different groups respond independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_events_i | input | N_GROUPS*2^CODE_W | Raw event bits, group g at bits g*2^CODE_W upward |
| orig_i | input | ORIG_W | Originator index of the current events |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration register address |
| cfg_wdata | input | 64 | Configuration write data |
| id_wr_en | input | 1 | Identifier update strobe |
| id_value | input | 12 | Identifier: code in 11:4, group in 3:0 |
| inc_o | output | N_CTRS | One increment pulse per counter |

## Verification
The main function is driven with single-hot event patterns. Each pattern is either the programmed code or a neighbouring code of the same group. This separates correct row selection from a slice that is merely adjacent or shifted. Patterns are sent to a group watched by one counter, by two counters, and through a restrictive filter with each originator value. These tell apart group decoding, fan-out to several counters, and filter bit indexing. Identifier sequences check the sequencer itself: back-to-back identifiers, invalid groups, a direct write that cancels a pending update, and a merge after a direct write. A wrong merge or a missing abort shows up as a pulse on the wrong code.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
    localparam int RES_W       = 64;
    localparam int EN_BIT      = 63;
    localparam int ADDR_W      = 12;
    localparam int ID_W        = 12;
    localparam int ID_GRP_W    = 4;
    localparam int TYPE_W      = 4;
    localparam int FILT_W      = 32;
    localparam logic [ADDR_W-1:0] RES_ADDR    = 12'h410;
    localparam logic [ADDR_W-1:0] FILT_BASE   = 12'h423;
    localparam logic [ADDR_W-1:0] TYPE_BASE   = 12'h424;
    localparam logic [ADDR_W-1:0] CTR_STRIDE  = 12'h010;
    localparam logic [FILT_W-1:0] FILT_PASS   = 32'h000E_0007;

    typedef enum logic [1:0] {
        UPD_IDLE   = 2'd0,
        UPD_FETCH  = 2'd1,
        UPD_COMMIT = 2'd2
    } upd_state_e;
endpackage

// File: rtl/evsel_residency.sv
module evsel_residency
    import evsel_pkg::*;
#(
    parameter int N_GROUPS = 8,
    parameter int CODE_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dir_wr,
    input  logic [RES_W-1:0]          dir_data,
    input  logic                      id_wr,
    input  logic [CODE_W-1:0]         id_code,
    input  logic [ID_GRP_W-1:0]       id_grp,
    output logic [RES_W-1:0]          res_q,
    output logic [N_GROUPS-1:0]       prog_q
);
    upd_state_e            state_q, state_d;
    logic [CODE_W-1:0]     pend_code;
    logic [ID_GRP_W-1:0]   pend_grp;
    logic [RES_W-1:0]      shadow_q;
    logic [RES_W-1:0]      merged;
    logic [RES_W-1:0]      keep_mask;
    logic                  id_ok;

    assign id_ok = (int'(id_grp) < N_GROUPS);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE:   if (!dir_wr && id_wr && id_ok) state_d = UPD_FETCH;
            UPD_FETCH:  state_d = dir_wr ? UPD_IDLE : UPD_COMMIT;
            UPD_COMMIT: state_d = UPD_IDLE;
            default:    state_d = UPD_IDLE;
        endcase
    end

    always_comb begin
        merged    = shadow_q;
        keep_mask = '1;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (g == int'(pend_grp)) begin
                merged[g*CODE_W +: CODE_W]    = pend_code;
                keep_mask[g*CODE_W +: CODE_W] = '0;
            end
        end
        merged[EN_BIT]    = 1'b1;
        keep_mask[EN_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_code <= '0;
            pend_grp  <= '0;
            shadow_q  <= '0;
            res_q     <= '0;
            prog_q    <= '0;
        end else begin
            if (state_q == UPD_IDLE && state_d == UPD_FETCH) begin
                pend_code <= id_code;
                pend_grp  <= id_grp;
            end
            if (state_q == UPD_FETCH) shadow_q <= res_q;
            if (dir_wr) begin
                res_q  <= dir_data;
                prog_q <= '1;
            end else if (state_q == UPD_COMMIT) begin
                res_q            <= merged;
                prog_q[pend_grp] <= 1'b1;
            end
        end
    end

    assert_commit_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UPD_COMMIT && !dir_wr) |=> (((res_q ^ $past(res_q)) & $past(keep_mask)) == '0));
    assert_commit_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UPD_COMMIT && !dir_wr) |=> res_q[EN_BIT]);
    assert_bad_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UPD_IDLE && id_wr && !id_ok && !dir_wr) |=> (state_q == UPD_IDLE && $stable(res_q)));
    assert_one_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UPD_COMMIT) |=> (state_q == UPD_IDLE));
    assert_direct_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (state_q == UPD_IDLE && res_q == $past(dir_data) && prog_q == '1));
endmodule

// File: rtl/evsel_group_pick.sv
module evsel_group_pick
    import evsel_pkg::*;
#(
    parameter int N_GROUPS = 8,
    parameter int CODE_W   = 8,
    parameter int ORIG_W   = 2,
    localparam int N_CODES = 1 << CODE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_GROUPS*N_CODES-1:0]  events_i,
    input  logic [ORIG_W-1:0]            orig_i,
    input  logic [RES_W-1:0]             res_q,
    input  logic [N_GROUPS-1:0]          prog_q,
    output logic [N_GROUPS-1:0]          sel_q,
    output logic [ORIG_W-1:0]            orig_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) orig_q <= '0;
        else        orig_q <= orig_i;
    end

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_col
        logic [N_CODES-1:0] row;
        logic [CODE_W-1:0]  code;
        assign row  = events_i[g*N_CODES +: N_CODES];
        assign code = res_q[g*CODE_W +: CODE_W];

        always_ff @(posedge clk) begin
            if (!rst_n) sel_q[g] <= 1'b0;
            else        sel_q[g] <= row[code] & res_q[EN_BIT] & prog_q[g];
        end

        assert_unprog_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !prog_q[g] |=> !sel_q[g]);
    end

    assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_q[EN_BIT] |=> (sel_q == '0));
endmodule

// File: rtl/evsel_route.sv
module evsel_route
    import evsel_pkg::*;
#(
    parameter int N_GROUPS = 8,
    parameter int N_CTRS   = 4,
    parameter int ORIG_W   = 2,
    localparam int GSEL_W  = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [FILT_W-1:0]    wr_data,
    input  logic [N_GROUPS-1:0]  sel_q,
    input  logic [ORIG_W-1:0]    orig_q,
    output logic [N_CTRS-1:0]    inc_o
);
    for (genvar i = 0; i < N_CTRS; i++) begin : g_ctr
        localparam logic [ADDR_W-1:0] TYPE_ADDR = TYPE_BASE + CTR_STRIDE * ADDR_W'(i);
        localparam logic [ADDR_W-1:0] FILT_ADDR = FILT_BASE + CTR_STRIDE * ADDR_W'(i);
        logic [TYPE_W-1:0] type_q;
        logic [FILT_W-1:0] filt_q;
        logic              grp_ok, line, pass;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                type_q <= '0;
                filt_q <= FILT_PASS;
            end else if (wr_en) begin
                if (wr_addr == TYPE_ADDR) type_q <= wr_data[TYPE_W-1:0];
                if (wr_addr == FILT_ADDR) filt_q <= wr_data;
            end
        end

        assign grp_ok   = (int'(type_q) < N_GROUPS);
        assign line     = grp_ok & sel_q[type_q[GSEL_W-1:0]];
        assign pass     = (filt_q == FILT_PASS) | filt_q[orig_q];
        assign inc_o[i] = line & pass;

        assert_type_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
            inc_o[i] |-> (int'(type_q) < N_GROUPS));
    end
endmodule

// File: rtl/evsel_matrix.sv
module evsel_matrix
    import evsel_pkg::*;
#(
    parameter int N_GROUPS = 8,
    parameter int CODE_W   = 8,
    parameter int N_CTRS   = 4,
    parameter int ORIG_W   = 2,
    localparam int N_CODES = 1 << CODE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_GROUPS*N_CODES-1:0]  grp_events_i,
    input  logic [ORIG_W-1:0]            orig_i,
    input  logic                         cfg_wr_en,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [RES_W-1:0]             cfg_wdata,
    input  logic                         id_wr_en,
    input  logic [ID_W-1:0]              id_value,
    output logic [N_CTRS-1:0]            inc_o
);
    logic [RES_W-1:0]     res_q;
    logic [N_GROUPS-1:0]  prog_q;
    logic [N_GROUPS-1:0]  sel_q;
    logic [ORIG_W-1:0]    orig_q;
    logic                 dir_wr;

    assign dir_wr = cfg_wr_en && (cfg_addr == RES_ADDR);

    evsel_residency #(.N_GROUPS(N_GROUPS), .CODE_W(CODE_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_wr   (dir_wr),
        .dir_data (cfg_wdata),
        .id_wr    (id_wr_en),
        .id_code  (id_value[ID_W-1 -: CODE_W]),
        .id_grp   (id_value[ID_GRP_W-1:0]),
        .res_q    (res_q),
        .prog_q   (prog_q)
    );

    evsel_group_pick #(.N_GROUPS(N_GROUPS), .CODE_W(CODE_W), .ORIG_W(ORIG_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .events_i (grp_events_i),
        .orig_i   (orig_i),
        .res_q    (res_q),
        .prog_q   (prog_q),
        .sel_q    (sel_q),
        .orig_q   (orig_q)
    );

    evsel_route #(.N_GROUPS(N_GROUPS), .N_CTRS(N_CTRS), .ORIG_W(ORIG_W)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata[FILT_W-1:0]),
        .sel_q   (sel_q),
        .orig_q  (orig_q),
        .inc_o   (inc_o)
    );

    assert_inc_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_o != '0) |-> $past(res_q[EN_BIT]));
endmodule

// File: tb/evsel_matrix_bench.sv
module evsel_matrix_bench;
    localparam int NG = 8;
    localparam int NC = 256;
    localparam int NK = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NG*NC-1:0]  ev;
    logic [1:0]        orig;
    logic              cfg_wr_en;
    logic [11:0]       cfg_addr;
    logic [63:0]       cfg_wdata;
    logic              id_wr_en;
    logic [11:0]       id_value;
    logic [NK-1:0]     inc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    evsel_matrix u_evsel_matrix (
        .clk          (clk),
        .rst_n        (rst_n),
        .grp_events_i (ev),
        .orig_i       (orig),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .id_wr_en     (id_wr_en),
        .id_value     (id_value),
        .inc_o        (inc)
    );

    // group, code, originator, expected increments
    localparam int NV = 7;
    localparam logic [23:0] VEC [NV] = '{
        {4'd0, 8'h05, 4'd0, 4'b0001, 4'd0},
        {4'd0, 8'h06, 4'd0, 4'b0000, 4'd0},
        {4'd3, 8'hA0, 4'd0, 4'b0110, 4'd0},
        {4'd3, 8'h05, 4'd0, 4'b0000, 4'd0},
        {4'd7, 8'hFF, 4'd0, 4'b1000, 4'd0},
        {4'd7, 8'hFF, 4'd1, 4'b0000, 4'd0},
        {4'd1, 8'h00, 4'd0, 4'b0000, 4'd0}
    };

    task automatic check(input logic [NK-1:0] exp, input string tag);
        checks++;
        if (inc !== exp) begin
            fails++;
            $display("FAIL %s: inc_o actual=%b expected=%b", tag, inc, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic id_write(input logic [11:0] v);
        @(negedge clk);
        id_wr_en = 1'b1; id_value = v;
        @(posedge clk);
        @(negedge clk);
        id_wr_en = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic fire(input int g, input int code, input logic [1:0] o,
                        input logic [NK-1:0] exp, input string tag);
        @(negedge clk);
        ev = '0;
        ev[g*NC + code] = 1'b1;
        orig = o;
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
        ev = '0;
        orig = '0;
        @(posedge clk);
    endtask

    function automatic logic [11:0] type_addr(input int i);
        return 12'h424 + 12'(16 * i);
    endfunction

    function automatic logic [11:0] filt_addr(input int i);
        return 12'h423 + 12'(16 * i);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ev = '0; orig = '0;
        cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        id_wr_en = 1'b0; id_value = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 / R8: nothing programmed, all events high, no pulses
        @(negedge clk);
        ev = '1;
        @(posedge clk);
        @(negedge clk);
        check(4'b0000, "R11 reset state quiet");
        ev = '0;

        // setup for the vector table
        id_write(12'h050);
        id_write(12'hA03);
        id_write(12'hFF7);
        reg_write(type_addr(1), 64'd3);
        reg_write(type_addr(2), 64'd3);
        reg_write(type_addr(3), 64'd7);
        reg_write(filt_addr(3), 64'h1);

        // R1 R12 R10 R8: table walk
        for (int k = 0; k < NV; k++) begin
            fire(int'(VEC[k][23:20]), int'(VEC[k][19:12]), VEC[k][9:8],
                 VEC[k][7:4], $sformatf("R1/R12/R10 vector %0d", k));
        end

        // R7: type out of range
        reg_write(type_addr(0), 64'd8);
        fire(0, 8'h05, 2'd0, 4'b0000, "R7 type 8 selects nothing");
        reg_write(type_addr(0), 64'd0);

        // R10 / R9: filter values
        reg_write(filt_addr(3), 64'h0);
        fire(7, 8'hFF, 2'd0, 4'b0000, "R10 filter zero blocks");
        reg_write(filt_addr(3), 64'h2);
        fire(7, 8'hFF, 2'd1, 4'b1000, "R10 filter bit 1 passes orig 1");
        reg_write(filt_addr(3), 64'h000E0007);
        fire(7, 8'hFF, 2'd3, 4'b1000, "R9 all-sources passes");

        // R4: invalid identifiers
        id_write(12'h0FE);
        id_write(12'h098);
        fire(0, 8'h05, 2'd0, 4'b0001, "R4 invalid ids ignored");

        // R5: back-to-back identifiers, second dropped
        @(negedge clk);
        id_wr_en = 1'b1; id_value = 12'h440;
        @(posedge clk);
        @(negedge clk);
        id_value = 12'h550;
        @(posedge clk);
        @(negedge clk);
        id_wr_en = 1'b0;
        repeat (3) @(posedge clk);
        fire(0, 8'h44, 2'd0, 4'b0001, "R5 first update applied");
        fire(0, 8'h55, 2'd0, 4'b0000, "R5 second update dropped");

        // R2: enable clear
        reg_write(12'h410, 64'h0000_0000_0000_2211);
        fire(0, 8'h11, 2'd0, 4'b0000, "R2 enable clear blocks");

        // R6: direct write sets all fields
        reg_write(12'h410, 64'h8000_0000_0000_2211);
        reg_write(type_addr(1), 64'd1);
        fire(1, 8'h22, 2'd0, 4'b0010, "R6 direct write group 1");

        // R3: merge keeps other groups
        id_write(12'h331);
        fire(1, 8'h33, 2'd0, 4'b0010, "R3 new code group 1");
        fire(0, 8'h11, 2'd0, 4'b0001, "R3 group 0 code kept");

        // R3: update sets enable
        reg_write(12'h410, 64'h0000_0000_0000_3311);
        id_write(12'h771);
        fire(1, 8'h77, 2'd0, 4'b0010, "R3 update sets enable");

        // R6: direct write cancels pending update
        @(negedge clk);
        id_wr_en = 1'b1; id_value = 12'h990;
        @(posedge clk);
        @(negedge clk);
        id_wr_en = 1'b0;
        cfg_wr_en = 1'b1; cfg_addr = 12'h410; cfg_wdata = 64'h8000_0000_0000_7712;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        repeat (3) @(posedge clk);
        fire(0, 8'h12, 2'd0, 4'b0001, "R6 direct value kept");
        fire(0, 8'h99, 2'd0, 4'b0000, "R6 pending update cancelled");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule